// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes stereo sample pairs from a valid/ready holding interface and shifts them out, MSB first, on a single serial data line. It also drives a bit clock and a left/right word clock. Each frame holds a left slot and then a right slot. Every slot is `SLOT_BITS` bit clocks long, 32 at the least. One serializer covers three framings. In I2S framing the data lags the word-clock edge by one bit clock. In left-justified framing the MSB starts on the word-clock edge. In right-justified framing the LSB lands on the last bit of the slot. Configuration inputs also select the word length and the polarity of each clock.

An external timing block supplies `half_tick`, which pulses once per half period of the bit clock. Ticks alternate between a launch half, where data, word clock and the launch edge of the bit clock change, and a capture half. A new pair is requested at the launch of the first bit of every frame. If no pair is offered, the block sends zeros for that frame and raises a one-cycle underflow pulse. Dropping `tx_en` silences the line and rewinds the frame, so the next enable starts on a left slot.

Top module: `i2s_tx_serializer`

## Requirements
- R1: `cfg_wlen` selects the sample width. Code 0 is 16 bits, 1 is 24 bits and 2 is 32 bits. The unused code 3 behaves as 32 bits.
- R2: Frame positions 0 to SLOT_BITS-1 form the left slot and the rest form the right slot. `ws_out` changes level only at launch of position 0 and position SLOT_BITS. It is low during the left slot when `cfg_ws_pol`=0 and high during the left slot when `cfg_ws_pol`=1. Bits go out MSB first.
- R3: With `cfg_delay`=1 and `cfg_rjust`=0 (I2S framing), the MSB of each channel is sent at slot position 1. At 32 bits the right-channel LSB is sent at position 0 of the following frame.
- R4: With `cfg_delay`=0 and `cfg_rjust`=0 (left-justified), the MSB is sent at slot position 0, and slot bits after the LSB are 0.
- R5: With `cfg_rjust`=1, the LSB is sent at the last slot position and the leading slot bits are 0. `cfg_delay` has no effect in this mode.
- R6: `sd_out` changes only at a launch. After each launch tick `bclk_out` equals `cfg_bclk_pol`, and after each capture tick it equals the inverse. So with polarity 0, data changes on the falling edge.
- R7: `pair_ready` is high only during the launch tick of frame position 0. The pair offered in that cycle is the one sent in that frame.
- R8: If `pair_valid` is low when `pair_ready` is high, the frame carries zeros in both slots, and `underflow` is high for exactly the next clock cycle.
- R9: While `tx_en` is low, `sd_out` is 0, `ws_out` holds the right-slot level, ticks have no effect and the stored samples clear. The first launch after enable is position 0 of a left slot.
- R10: Only the low bits of `pair_left` and `pair_right` are used, as many as the sample width. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| half_tick | input | 1 | Half bit-clock period enable from the timing block |
| cfg_wlen | input | 2 | Word length code (0:16, 1:24, 2/3:32) |
| cfg_rjust | input | 1 | Right-justify the sample in its slot |
| cfg_delay | input | 1 | One bit-clock data delay after the word-clock edge |
| cfg_ws_pol | input | 1 | Word-clock level during the left slot |
| cfg_bclk_pol | input | 1 | Bit-clock level right after a data launch |
| pair_valid | input | 1 | A stereo pair is offered |
| pair_left | input | 32 | Left sample, right-aligned |
| pair_right | input | 32 | Right sample, right-aligned |
| pair_ready | output | 1 | The pair is taken in this cycle |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word clock |
| bclk_out | output | 1 | Bit clock |
| underflow | output | 1 | One-cycle pulse when a frame started without a pair |

## Verification
The assertions assume two things. First, the configuration inputs do not change while `tx_en` is high, so the word-clock and data stability properties can tie level changes to launch ticks alone. Second, `half_tick` is a single-cycle pulse with idle cycles between pulses. The stimulus meets both assumptions. It changes configuration only while the block is disabled. It drives every tick as one clock high followed by one clock low.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        WLEN_16  = 2'd0,
        WLEN_24  = 2'd1,
        WLEN_32  = 2'd2,
        WLEN_RSV = 2'd3
    } wlen_e;

    localparam int SMP_W = 32;

    // Number of sample bits for a word length code; the spare code acts as 32.
    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        case (wlen_e'(code))
            WLEN_16: wlen_bits = 6'd16;
            WLEN_24: wlen_bits = 6'd24;
            default: wlen_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/i2s_tx_timer.sv
module i2s_tx_timer #(
    parameter int SLOT_BITS = 32,
    parameter int POS_W     = $clog2(2 * SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             half_tick,
    output logic             launch,
    output logic [POS_W-1:0] pos_q,
    output logic             phase_q
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    // phase: 1 = capture half done, next tick launches
    typedef struct packed {
        logic             phase;
        logic [POS_W-1:0] pos;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        if (!tx_en) begin
            st_d.phase = 1'b1;
            st_d.pos   = '0;
        end else if (half_tick) begin
            if (st_q.phase) begin
                launch     = 1'b1;
                st_d.phase = 1'b0;
                st_d.pos   = (st_q.pos == LAST_POS) ? '0 : st_q.pos + 1'b1;
            end else begin
                st_d.phase = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= 1'b1;
            st_q.pos   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q   = st_q.pos;
    assign phase_q = st_q.phase;

    // R6
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && half_tick) |=> (phase_q != $past(phase_q)));

    // R9
    idle_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (pos_q == '0 && phase_q));

endmodule

// File: rtl/i2s_tx_bitsel.sv
module i2s_tx_bitsel
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int POS_W     = $clog2(2 * SLOT_BITS)
) (
    input  logic [POS_W-1:0] pos,
    input  logic             delay_on,
    input  logic             rjust,
    input  logic [1:0]       wlen,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    output logic             bit_o
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;

    int               q_i;
    int               k_i;
    int               n_i;
    int               off_i;
    int               j_i;
    logic [SMP_W-1:0] smp;

    always_comb begin
        // data index lags the frame position by the optional delay
        q_i = int'(pos) - (delay_on ? 1 : 0);
        if (q_i < 0) begin
            q_i = FRAME_BITS - 1;
        end
        if (q_i >= SLOT_BITS) begin
            smp = right_smp;
            k_i = q_i - SLOT_BITS;
        end else begin
            smp = left_smp;
            k_i = q_i;
        end
        n_i   = int'(wlen_bits(wlen));
        off_i = rjust ? (SLOT_BITS - n_i) : 0;
        j_i   = k_i - off_i;
        bit_o = 1'b0;
        if (j_i >= 0 && j_i < n_i) begin
            bit_o = smp[5'(n_i - 1 - j_i)];
        end
    end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        half_tick,
    input  logic [1:0]  cfg_wlen,
    input  logic        cfg_rjust,
    input  logic        cfg_delay,
    input  logic        cfg_ws_pol,
    input  logic        cfg_bclk_pol,
    input  logic        pair_valid,
    input  logic [31:0] pair_left,
    input  logic [31:0] pair_right,
    output logic        pair_ready,
    output logic        sd_out,
    output logic        ws_out,
    output logic        bclk_out,
    output logic        underflow
);
    localparam int POS_W = $clog2(2 * SLOT_BITS);
    localparam logic [POS_W-1:0] RIGHT_START = POS_W'(SLOT_BITS);

    typedef struct packed {
        logic             sd;
        logic             in_right;
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
        logic             uflow;
    } ser_t;

    ser_t st_d, st_q;

    logic             launch;
    logic [POS_W-1:0] pos;
    logic             phase;
    logic             frame_start;
    logic             delay_on;
    logic [SMP_W-1:0] new_left;
    logic [SMP_W-1:0] new_right;
    logic [SMP_W-1:0] left_src;
    logic             next_bit;

    i2s_tx_timer #(
        .SLOT_BITS (SLOT_BITS),
        .POS_W     (POS_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .half_tick (half_tick),
        .launch    (launch),
        .pos_q     (pos),
        .phase_q   (phase)
    );

    assign frame_start = launch && (pos == '0);
    assign delay_on    = cfg_delay & ~cfg_rjust;
    assign new_left    = pair_valid ? pair_left  : '0;
    assign new_right   = pair_valid ? pair_right : '0;
    // at frame start the left data comes straight from the incoming pair
    assign left_src    = (pos == '0) ? new_left : st_q.left;

    i2s_tx_bitsel #(
        .SLOT_BITS (SLOT_BITS),
        .POS_W     (POS_W)
    ) u_bitsel (
        .pos       (pos),
        .delay_on  (delay_on),
        .rjust     (cfg_rjust),
        .wlen      (cfg_wlen),
        .left_smp  (left_src),
        .right_smp (st_q.right),
        .bit_o     (next_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.uflow = 1'b0;
        if (!tx_en) begin
            st_d.sd       = 1'b0;
            st_d.in_right = 1'b1;
            st_d.left     = '0;
            st_d.right    = '0;
        end else if (launch) begin
            st_d.sd       = next_bit;
            st_d.in_right = (pos >= RIGHT_START);
            if (frame_start) begin
                st_d.left  = new_left;
                st_d.right = new_right;
                st_d.uflow = ~pair_valid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sd       <= 1'b0;
            st_q.in_right <= 1'b1;
            st_q.left     <= '0;
            st_q.right    <= '0;
            st_q.uflow    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_ready = frame_start;
    assign sd_out     = st_q.sd;
    assign ws_out     = st_q.in_right ^ cfg_ws_pol;
    assign bclk_out   = phase ^ cfg_bclk_pol;
    assign underflow  = st_q.uflow;

    // R9
    sd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sd_out);

    // R6
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !half_tick) |=> $stable(sd_out));

    // R2
    ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !half_tick) |=> $stable(ws_out));

    // R8
    uflow_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

    // R8
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(pair_ready && !pair_valid));

    // R7
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> (tx_en && half_tick));

endmodule

// File: tb/i2s_tx_serializer_tb.sv
module i2s_tx_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int S = 32;
    localparam int F = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        half_tick = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic        cfg_rjust = 1'b0;
    logic        cfg_delay = 1'b0;
    logic        cfg_ws_pol = 1'b0;
    logic        cfg_bclk_pol = 1'b0;
    logic        pair_valid = 1'b0;
    logic [31:0] pair_left = '0;
    logic [31:0] pair_right = '0;
    logic        pair_ready;
    logic        sd_out;
    logic        ws_out;
    logic        bclk_out;
    logic        underflow;

    int tests = 0;
    int fails = 0;
    logic ready_at_tick;

    i2s_tx_serializer #(.SLOT_BITS(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .half_tick(half_tick),
        .cfg_wlen(cfg_wlen), .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay),
        .cfg_ws_pol(cfg_ws_pol), .cfg_bclk_pol(cfg_bclk_pol),
        .pair_valid(pair_valid), .pair_left(pair_left), .pair_right(pair_right),
        .pair_ready(pair_ready), .sd_out(sd_out), .ws_out(ws_out),
        .bclk_out(bclk_out), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
    endfunction

    // Expected serial bits of one frame, built from the framing rules.
    function automatic logic [63:0] exp_frame(input logic d, input logic rj, input int n,
                                              input logic [31:0] l, input logic [31:0] r,
                                              input logic [31:0] pr);
        logic [63:0] v = '0;
        for (int p = 0; p < F; p++) begin
            int dl = (d && !rj) ? 1 : 0;
            int idx = (p + F - dl) % F;
            int k = idx % S;
            int first = rj ? S - n : 0;
            logic [31:0] w = (idx >= S) ? ((p < dl) ? pr : r) : l;
            if (k >= first && k < first + n) v[p] = w[n - 1 - (k - first)];
        end
        return v;
    endfunction

    task automatic half();
        @(negedge clk);
        half_tick = 1'b1;
        #1 ready_at_tick = pair_ready;
        @(negedge clk);
        half_tick = 1'b0;
    endtask

    task automatic frame(input logic v, input logic [31:0] l, input logic [31:0] r,
                         output logic [63:0] sd_bits, output logic [63:0] ws_bits,
                         output logic rdy0, output logic uf0, output logic uf1,
                         output int bad);
        bad = 0;
        rdy0 = 1'b0; uf0 = 1'b0; uf1 = 1'b0;
        pair_valid = v; pair_left = l; pair_right = r;
        for (int p = 0; p < F; p++) begin
            half();
            sd_bits[p] = sd_out;
            ws_bits[p] = ws_out;
            if (p == 0) begin
                rdy0 = ready_at_tick;
                uf0 = underflow;
                pair_valid = 1'b0;
                pair_left = 32'hDEAD_BEEF;
                pair_right = 32'hDEAD_BEEF;
            end else if (ready_at_tick) bad++;
            if (bclk_out !== cfg_bclk_pol) bad++;
            half();
            if (p == 0) uf1 = underflow;
            if (bclk_out !== ~cfg_bclk_pol) bad++;
        end
    endtask

    function automatic logic [63:0] ws_exp();
        return {{32{~cfg_ws_pol}}, {32{cfg_ws_pol}}};
    endfunction

    task automatic setup(input logic [1:0] wl, input logic rj, input logic d,
                         input logic wp, input logic bp);
        @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg_wlen = wl; cfg_rjust = rj; cfg_delay = d;
        cfg_ws_pol = wp; cfg_bclk_pol = bp;
        @(negedge clk);
        tx_en = 1'b1;
    endtask

    // Two back-to-back frames, checking data, word clock, bit clock and ready.
    task automatic two_frames(input string tag, input logic [31:0] l1, input logic [31:0] r1,
                              input logic [31:0] l2, input logic [31:0] r2);
        logic [63:0] sdb, wsb;
        logic rdy, u0, u1;
        int bad;
        int n = wbits(cfg_wlen);
        frame(1'b1, l1, r1, sdb, wsb, rdy, u0, u1, bad);
        chk({tag, " frame1 data"}, sdb, exp_frame(cfg_delay, cfg_rjust, n, l1, r1, 32'h0));
        chk({tag, " frame1 ws R2"}, wsb, ws_exp());
        chk({tag, " ready R7 / bclk R6"}, {rdy, u0, 30'(bad)}, {1'b1, 1'b0, 30'd0});
        frame(1'b1, l2, r2, sdb, wsb, rdy, u0, u1, bad);
        chk({tag, " frame2 data"}, sdb, exp_frame(cfg_delay, cfg_rjust, n, l2, r2, r1));
        chk({tag, " frame2 bclk R6"}, 64'(bad), 64'd0);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("reset R9", {59'd0, sd_out, ws_out, bclk_out, pair_ready, underflow},
            {59'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_i2s16();
        // R3 R1 R10: I2S framing, 16 bits, upper input bits are junk
        setup(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        two_frames("R3 i2s16 R10", 32'h5A5A_C3A1, 32'hFFFF_8E17, 32'h1234_7F02, 32'h0F0F_B6D9);
    endtask

    task automatic t_lj24();
        // R4 R1 R2: left-justified, 24 bits, both polarities inverted
        setup(2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
        two_frames("R4 lj24", 32'hAB96_3C71, 32'h00F0_0F5A, 32'h77C1_D2E3, 32'hFF81_2345);
    endtask

    task automatic t_rj16();
        // R5: right-justified, delay control set but must have no effect
        setup(2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        two_frames("R5 rj16", 32'h0000_9C35, 32'hEEEE_4E81, 32'h0000_8001, 32'h0000_F00D);
    endtask

    task automatic t_w32();
        // R1 R3: 32-bit I2S, right LSB spills into next frame
        setup(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        two_frames("R1 w32 i2s", 32'h8123_4567, 32'h89AB_CDEF, 32'h7654_3211, 32'hC0FF_EE01);
        // R1: spare code behaves as 32 bits
        setup(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        two_frames("R1 code3", 32'hF00D_CAFE, 32'h1357_9BDF, 32'h2468_ACE1, 32'hFEED_0003);
    endtask

    task automatic t_underflow();
        logic [63:0] sdb, wsb;
        logic rdy, u0, u1;
        int bad;
        setup(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        frame(1'b1, 32'h0000_ABCD, 32'h0000_1234, sdb, wsb, rdy, u0, u1, bad);
        chk("R8 no underflow with pair", {62'd0, u0, u1}, 64'd0);
        frame(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, sdb, wsb, rdy, u0, u1, bad);
        chk("R8 zeros on underflow", sdb, 64'd0);
        chk("R8 pulse one cycle", {61'd0, rdy, u0, u1}, {61'd0, 1'b1, 1'b1, 1'b0});
        frame(1'b1, 32'h0000_6D2B, 32'h0000_91E4, sdb, wsb, rdy, u0, u1, bad);
        chk("R8 recovery", sdb, exp_frame(1'b0, 1'b0, 16, 32'h6D2B, 32'h91E4, 32'h0));
    endtask

    task automatic t_disable();
        logic [63:0] sdb, wsb;
        logic rdy, u0, u1;
        int bad;
        setup(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        pair_valid = 1'b1; pair_left = 32'hFFFF_FFFF; pair_right = 32'hFFFF_FFFF;
        for (int i = 0; i < 20; i++) half();
        pair_valid = 1'b0;
        @(negedge clk);
        tx_en = 1'b0;
        for (int i = 0; i < 6; i++) half();
        chk("R9 idle outputs", {61'd0, sd_out, ws_out, underflow}, {61'd0, 1'b0, 1'b1, 1'b0});
        @(negedge clk);
        tx_en = 1'b1;
        frame(1'b1, 32'h9ABC_DEF0, 32'h1111_2223, sdb, wsb, rdy, u0, u1, bad);
        chk("R9 restart left slot data", sdb,
            exp_frame(1'b1, 1'b0, 32, 32'h9ABC_DEF0, 32'h1111_2223, 32'h0));
        chk("R9 restart ws", wsb, ws_exp());
        chk("R9 restart ready", {63'd0, rdy}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_i2s16();
        t_lj24();
        t_rj16();
        t_w32();
        t_underflow();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule